// File: doc/BRIEF.md
# MII Nibble Transmit Serializer

This block turns a stream of transmit bytes into the 4-bit nibble stream of a Media Independent Interface transmitter. It runs entirely in the transmit clock domain supplied by the PHY, so one nibble leaves the block on every rising edge of that clock. A frame begins when the byte source raises `in_valid`. The block then sends a run of preamble nibbles and a start-of-frame nibble. After that it sends every byte as two nibbles, low half first. Finally it drops transmit enable and holds the line idle for a fixed minimum gap.

The byte source uses a valid/ready handshake. The block stores one byte at a time and asks for the next byte only in the nibble cycle just before that byte is needed: the start-of-frame cycle, or the high-nibble cycle of a byte that is not the last one. If no byte is offered at that moment, the frame is cut short. The block then sends one error-flagged nibble and goes into the gap. A byte marked errored by the source is sent with transmit error high on both of its nibbles.

Control is one state machine with seven states:
- IDLE: waiting for `in_valid`.
- PREAMBLE: counting out the preamble nibbles.
- SFD: sending the start-of-frame nibble.
- DATA_LO and DATA_HI: sending the two halves of a byte.
- ABORT: sending the single nibble after an underrun.
- GAP: counting the idle nibbles after a frame.

The transitions are:
- IDLE→PREAMBLE on `in_valid`.
- PREAMBLE→SFD after the last preamble nibble.
- SFD→DATA_LO when a byte is taken, or SFD→ABORT when none is offered.
- DATA_LO→DATA_HI always.
- DATA_HI→GAP after the last byte.
- DATA_HI→DATA_LO when the next byte is taken.
- DATA_HI→ABORT on underrun.
- ABORT→GAP always.
- GAP→IDLE after the gap count.

Top module: `mii_tx_serializer`

## Requirements
- R1: While `rst_n` is low at a rising edge, the block returns to IDLE. It then holds `mii_tx_en`, `mii_tx_er`, `in_ready` and `mii_txd` at 0.
- R2: Whenever `mii_tx_en` is 0, `mii_txd` is 4'h0 and `mii_tx_er` is 0.
- R3: In the cycle after an edge that sees `in_valid` high in IDLE, `mii_tx_en` rises with `mii_txd` = 4'h5. Exactly PRE_NIBBLES (default 15) nibbles of 4'h5 are sent, then one nibble of 4'hD. `mii_tx_en` stays high throughout.
- R4: Each accepted byte is sent as two consecutive nibbles: bits [3:0] first, then bits [7:4]. The first of them follows the start-of-frame nibble or the previous byte's high nibble.
- R5: `mii_tx_er` is high on both nibbles of a byte accepted with `in_err` = 1. It is low on all preamble, start-of-frame and clean-byte nibbles.
- R6: `in_ready` is 1 only during the start-of-frame nibble and during the high nibble of a byte accepted with `in_last` = 0. A byte is taken at an edge where `in_valid` and `in_ready` are both 1.
- R7: After the high nibble of a byte accepted with `in_last` = 1, `mii_tx_en` is 0 in the very next cycle.
- R8: If `in_valid` is 0 while `in_ready` is 1, the next nibble is a single abort nibble with `mii_tx_en` = 1, `mii_tx_er` = 1 and `mii_txd` = 4'h0. After it, `mii_tx_en` falls.
- R9: After `mii_tx_en` falls, it stays low for IFG_NIBBLES (default 24) cycles of GAP plus one cycle of IDLE before the next preamble can start. With `in_valid` already high, the preamble starts exactly IFG_NIBBLES+1 cycles after the fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit nibble clock from the PHY |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | A byte is offered on `in_data` |
| in_data | input | 8 | Byte to transmit |
| in_last | input | 1 | The offered byte ends the frame |
| in_err | input | 1 | The offered byte is to be sent with transmit error |
| in_ready | output | 1 | The block takes the offered byte at this edge |
| mii_txd | output | 4 | Transmit data nibble |
| mii_tx_en | output | 1 | Transmit enable |
| mii_tx_er | output | 1 | Transmit error |

## Verification
The bench builds the block with its default values, PRE_NIBBLES = 15 and IFG_NIBBLES = 24. With these values the full-length preamble and the exact 25-cycle low stretch between frames are checked nibble by nibble. The 25 cycles are the gap count plus the IDLE cycle. The reference model predicts every nibble and every `in_ready` cycle of each frame. It covers several byte patterns, an errored byte, a one-byte frame, underruns both at the start-of-frame nibble and mid-frame, and a start delayed by extra idle cycles.

// File: rtl/mii_tx_pkg.sv
`timescale 1ns/1ps
package mii_tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREAMBLE,
        ST_SFD,
        ST_DATA_LO,
        ST_DATA_HI,
        ST_ABORT,
        ST_GAP
    } tx_state_e;

    localparam logic [3:0] NIB_PREAMBLE = 4'h5;
    localparam logic [3:0] NIB_SFD      = 4'hD;
    localparam logic [3:0] NIB_IDLE     = 4'h0;

endpackage

// File: rtl/mii_tx_fsm.sv
`timescale 1ns/1ps
module mii_tx_fsm
    import mii_tx_pkg::*;
#(
    parameter int PRE_NIBBLES = 15,
    parameter int IFG_NIBBLES = 24,
    parameter int CNT_W       = 5
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      in_valid,
    input  logic      byte_last,
    output tx_state_e state,
    output logic      take,
    output logic      ready
);

    localparam logic [CNT_W-1:0] PRE_LAST = CNT_W'(PRE_NIBBLES - 1);
    localparam logic [CNT_W-1:0] IFG_LAST = CNT_W'(IFG_NIBBLES - 1);

    tx_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q + 1'b1;
        unique case (state_q)
            ST_IDLE: begin
                cnt_d = '0;
                if (in_valid) state_d = ST_PREAMBLE;
            end
            ST_PREAMBLE: begin
                if (cnt_q == PRE_LAST) state_d = ST_SFD;
            end
            ST_SFD: begin
                cnt_d   = '0;
                state_d = in_valid ? ST_DATA_LO : ST_ABORT;
            end
            ST_DATA_LO: begin
                cnt_d   = '0;
                state_d = ST_DATA_HI;
            end
            ST_DATA_HI: begin
                cnt_d = '0;
                if (byte_last)     state_d = ST_GAP;
                else if (in_valid) state_d = ST_DATA_LO;
                else               state_d = ST_ABORT;
            end
            ST_ABORT: begin
                cnt_d   = '0;
                state_d = ST_GAP;
            end
            ST_GAP: begin
                if (cnt_q == IFG_LAST) state_d = ST_IDLE;
            end
            default: begin
                cnt_d   = '0;
                state_d = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        ready = (state_q == ST_SFD) || ((state_q == ST_DATA_HI) && !byte_last);
        take  = ready && in_valid;
        state = state_q;
    end

    // R8: an offered slot left empty leads straight into the abort nibble
    a_r8_underrun_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !in_valid) |=> (state_q == ST_ABORT));

    // R3: preamble counter advances by one on every preamble nibble
    a_r3_preamble_step: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PREAMBLE && $past(state_q) == ST_PREAMBLE) |-> (cnt_q == $past(cnt_q) + 1'b1));

    // R4: a low nibble only follows the start-of-frame nibble or a high nibble
    a_r4_low_after_sfd_or_high: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DATA_LO) |-> ($past(state_q) == ST_SFD || $past(state_q) == ST_DATA_HI));

endmodule

// File: rtl/mii_tx_byte_reg.sv
`timescale 1ns/1ps
module mii_tx_byte_reg #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic [BYTE_W-1:0] d_in,
    input  logic              err_in,
    input  logic              last_in,
    output logic [BYTE_W-1:0] d_q,
    output logic              err_q,
    output logic              last_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            d_q    <= '0;
            err_q  <= 1'b0;
            last_q <= 1'b0;
        end else if (take) begin
            d_q    <= d_in;
            err_q  <= err_in;
            last_q <= last_in;
        end
    end

endmodule

// File: rtl/mii_tx_nibble_out.sv
`timescale 1ns/1ps
module mii_tx_nibble_out
    import mii_tx_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  tx_state_e         state,
    input  logic [BYTE_W-1:0] byte_q,
    input  logic              err_q,
    output logic [3:0]        txd,
    output logic              tx_en,
    output logic              tx_er
);

    always_comb begin
        txd   = NIB_IDLE;
        tx_en = 1'b0;
        tx_er = 1'b0;
        unique case (state)
            ST_IDLE, ST_GAP: begin
                txd   = NIB_IDLE;
            end
            ST_PREAMBLE: begin
                tx_en = 1'b1;
                txd   = NIB_PREAMBLE;
            end
            ST_SFD: begin
                tx_en = 1'b1;
                txd   = NIB_SFD;
            end
            ST_DATA_LO: begin
                tx_en = 1'b1;
                tx_er = err_q;
                txd   = byte_q[3:0];
            end
            ST_DATA_HI: begin
                tx_en = 1'b1;
                tx_er = err_q;
                txd   = byte_q[7:4];
            end
            ST_ABORT: begin
                tx_en = 1'b1;
                tx_er = 1'b1;
                txd   = NIB_IDLE;
            end
            default: begin
                txd   = NIB_IDLE;
            end
        endcase
    end

endmodule

// File: rtl/mii_tx_serializer.sv
`timescale 1ns/1ps
module mii_tx_serializer
    import mii_tx_pkg::*;
#(
    parameter int PRE_NIBBLES = 15,
    parameter int IFG_NIBBLES = 24
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic [7:0] in_data,
    input  logic       in_last,
    input  logic       in_err,
    output logic       in_ready,
    output logic [3:0] mii_txd,
    output logic       mii_tx_en,
    output logic       mii_tx_er
);

    localparam int BYTE_W  = 8;
    localparam int CNT_MAX = (PRE_NIBBLES > IFG_NIBBLES) ? PRE_NIBBLES : IFG_NIBBLES;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    tx_state_e         state;
    logic              take;
    logic [BYTE_W-1:0] byte_q;
    logic              err_q;
    logic              last_q;

    mii_tx_fsm #(
        .PRE_NIBBLES(PRE_NIBBLES),
        .IFG_NIBBLES(IFG_NIBBLES),
        .CNT_W      (CNT_W)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .byte_last(last_q),
        .state    (state),
        .take     (take),
        .ready    (in_ready)
    );

    mii_tx_byte_reg #(
        .BYTE_W(BYTE_W)
    ) u_byte (
        .clk    (clk),
        .rst_n  (rst_n),
        .take   (take),
        .d_in   (in_data),
        .err_in (in_err),
        .last_in(in_last),
        .d_q    (byte_q),
        .err_q  (err_q),
        .last_q (last_q)
    );

    mii_tx_nibble_out #(
        .BYTE_W(BYTE_W)
    ) u_out (
        .state (state),
        .byte_q(byte_q),
        .err_q (err_q),
        .txd   (mii_txd),
        .tx_en (mii_tx_en),
        .tx_er (mii_tx_er)
    );

    // Length of the current low stretch of transmit enable, saturating at the gap
    logic [CNT_W-1:0] idle_run;
    always_ff @(posedge clk) begin
        if (!rst_n)                                 idle_run <= CNT_W'(IFG_NIBBLES);
        else if (mii_tx_en)                         idle_run <= '0;
        else if (idle_run != CNT_W'(IFG_NIBBLES))   idle_run <= idle_run + 1'b1;
    end

    // R9: a new frame never starts before the minimum gap has elapsed
    a_r9_min_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mii_tx_en) |-> (idle_run == CNT_W'(IFG_NIBBLES)));

    // R3: the first nibble under transmit enable is a preamble nibble
    a_r3_starts_with_preamble: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mii_tx_en) |-> (mii_txd == NIB_PREAMBLE && !mii_tx_er));

endmodule

// File: tb/tb_mii_tx_serializer.sv
`timescale 1ns/1ps
module tb_mii_tx_serializer;

    localparam int PRE = 15;
    localparam int IFG = 24;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_last = 1'b0;
    logic       in_err = 1'b0;
    logic       in_ready;
    logic [3:0] mii_txd;
    logic       mii_tx_en;
    logic       mii_tx_er;

    always #4 clk = ~clk;

    mii_tx_serializer #(.PRE_NIBBLES(PRE), .IFG_NIBBLES(IFG)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_last(in_last), .in_err(in_err), .in_ready(in_ready),
        .mii_txd(mii_txd), .mii_tx_en(mii_tx_en), .mii_tx_er(mii_tx_er)
    );

    typedef struct {
        logic       en;
        logic       er;
        logic [3:0] d;
        logic       rdy;
        string      tag;
    } exp_t;

    exp_t       expq[$];
    int         n_checks = 0;
    int         n_errors = 0;
    bit         mon_on = 1'b0;
    bit         done = 1'b0;
    logic [7:0] fb[16];
    logic       fe[16];

    function automatic void push(logic en, logic er, logic [3:0] d, logic rdy, string tag);
        exp_t e;
        e.en = en; e.er = er; e.d = d; e.rdy = rdy; e.tag = tag;
        expq.push_back(e);
    endfunction

    // Reference model: every nibble and ready cycle of one frame, computed from the requirements
    task automatic send_frame(input int n, input int cut);
        int nb;
        nb = (cut < 0) ? n : cut;
        for (int i = 0; i < PRE; i++) push(1'b1, 1'b0, 4'h5, 1'b0, "R3 preamble");
        push(1'b1, 1'b0, 4'hD, 1'b1, "R3/R6 sfd");
        for (int i = 0; i < nb; i++) begin
            push(1'b1, fe[i], fb[i][3:0], 1'b0, "R4/R5 low nibble");
            push(1'b1, fe[i], fb[i][7:4], (cut >= 0) || (i != n - 1), "R4/R6 high nibble");
        end
        if (cut >= 0) push(1'b1, 1'b1, 4'h0, 1'b0, "R8 abort");
        push(1'b0, 1'b0, 4'h0, 1'b0, "R7 enable drop");
        for (int i = 1; i < IFG; i++) push(1'b0, 1'b0, 4'h0, 1'b0, "R9 gap");
        push(1'b0, 1'b0, 4'h0, 1'b0, "R9 idle");

        in_valid = 1'b1;
        in_data  = fb[0];
        in_err   = fe[0];
        in_last  = (n == 1);
        if (cut == 0) begin
            @(posedge clk);
            @(negedge clk);
            in_valid = 1'b0;
        end else begin
            for (int i = 0; i < nb; i++) begin
                in_valid = 1'b1;
                in_data  = fb[i];
                in_err   = fe[i];
                in_last  = (cut < 0) && (i == n - 1);
                while (!in_ready) @(negedge clk);
                @(negedge clk);
            end
            in_valid = 1'b0;
            in_data  = 8'hAA;
            in_err   = 1'b0;
            in_last  = 1'b0;
        end
        while (expq.size() != 0) @(negedge clk);
    endtask

    // Cycle-by-cycle comparison, sampled 3 ns after each rising edge
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            #3;
            if (mon_on && !done) begin
                if (expq.size() > 0) e = expq.pop_front();
                else begin
                    e.en = 1'b0; e.er = 1'b0; e.d = 4'h0; e.rdy = 1'b0; e.tag = "R2 idle line";
                end
                n_checks++;
                if (mii_tx_en !== e.en || mii_tx_er !== e.er || mii_txd !== e.d || in_ready !== e.rdy) begin
                    n_errors++;
                    $display("FAIL %s at %0t: actual en=%b er=%b txd=%h rdy=%b expected en=%b er=%b txd=%h rdy=%b",
                             e.tag, $time, mii_tx_en, mii_tx_er, mii_txd, in_ready, e.en, e.er, e.d, e.rdy);
                end
                n_checks++;
                if (!mii_tx_en && (mii_txd !== 4'h0 || mii_tx_er !== 1'b0)) begin
                    n_errors++;
                    $display("FAIL R2 at %0t: actual txd=%h er=%b with enable low, expected txd=0 er=0",
                             $time, mii_txd, mii_tx_er);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_errors++;
            $display("FAIL watchdog: actual run still busy, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        n_checks++;
        if (mii_tx_en !== 1'b0 || mii_tx_er !== 1'b0 || mii_txd !== 4'h0 || in_ready !== 1'b0) begin
            n_errors++;
            $display("FAIL R1: actual en=%b er=%b txd=%h rdy=%b expected all zero",
                     mii_tx_en, mii_tx_er, mii_txd, in_ready);
        end
        in_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        n_checks++;
        if (mii_tx_en !== 1'b0) begin
            n_errors++;
            $display("FAIL R1: actual en=%b while held in reset, expected 0", mii_tx_en);
        end
        in_valid = 1'b0;
        rst_n = 1'b1;
        mon_on = 1'b1;
        repeat (2) @(negedge clk);

        // three clean bytes
        fb[0] = 8'h3C; fb[1] = 8'hA5; fb[2] = 8'h71;
        fe[0] = 1'b0;  fe[1] = 1'b0;  fe[2] = 1'b0;
        send_frame(3, -1);

        // errored second byte (R5)
        fb[0] = 8'h12; fb[1] = 8'hF0; fb[2] = 8'h0F; fb[3] = 8'h88;
        fe[0] = 1'b0;  fe[1] = 1'b1;  fe[2] = 1'b0;  fe[3] = 1'b0;
        send_frame(4, -1);

        // single-byte frame started straight after the gap (R7, R9)
        fb[0] = 8'hE7; fe[0] = 1'b0;
        send_frame(1, -1);

        // underrun after two of four bytes (R8)
        fb[0] = 8'h9B; fb[1] = 8'h46; fb[2] = 8'h11; fb[3] = 8'h22;
        fe[0] = 1'b0;  fe[1] = 1'b0;  fe[2] = 1'b0;  fe[3] = 1'b0;
        send_frame(4, 2);

        // underrun at the start-of-frame nibble (R8)
        fb[0] = 8'h5A; fe[0] = 1'b0;
        send_frame(3, 0);

        // late start after extra idle cycles, extreme byte values, error on last byte
        repeat (10) @(negedge clk);
        fb[0] = 8'h00; fb[1] = 8'hFF;
        fe[0] = 1'b0;  fe[1] = 1'b1;
        send_frame(2, -1);

        repeat (4) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule